// File: doc/BRIEF.md
# Wide Register-Slice Transfer RAM

This block is a scratch RAM that a processor core reaches through a wide register-transfer port instead of ordinary loads and stores. One transfer carries up to 32 bytes, the contents of a run of consecutive 32-bit core registers, into or out of a single 256-bit RAM row in one clock. A 16-bit control word, also written over the transfer port, holds the current row index and an auto-increment enable. Once auto-increment is on, each data transfer steps the index to the next row.

Every transfer carries a device ID. ID 48 gives plain read/write access to the RAM and to the control word. ID 49 is a write-only snoop mode: it stores a full row and also presents that row on a snoop output, where a downstream checksum engine picks it up. Reading takes two transfers: a control write sets the index, then a data read transfer returns the row one cycle later.

Top module: `wide_xfer_ram`

## Requirements
- R1: After reset, `rd_valid` and `snoop_valid` are low, the row index is 0 and auto-increment is off.
- R2: A plain write uses device 48 with `xfr_write`=1. The start register r must be in 2..9 and the byte count L in 1..32, with byte offset o=(r-2)*4 and o+L<=32. It updates bytes o..o+L-1 of the indexed row. Row byte k takes `xfr_wdata[8k+7:8k]` and every other byte of the row keeps its value.
- R3: A plain read uses device 48 with `xfr_write`=0 and the same register and count rules. It raises `rd_valid` for exactly one cycle, on the cycle after the transfer, with the whole 256-bit indexed row on `rd_data`.
- R4: A control write uses device 48, `xfr_write`=1, start register 10 and byte count 2. It loads the index from `xfr_wdata[8:0]` and auto-increment from `xfr_wdata[15]`. A transfer to register 10 with any other byte count has no effect.
- R5: With auto-increment on, each accepted plain read, plain write or snoop write advances the index by exactly one row, whatever its byte count. With auto-increment off, the index does not change.
- R6: The index saturates at 511 and never wraps to 0. Only a control write moves it away from 511.
- R7: A snoop write uses device 49, `xfr_write`=1, start register 2 and byte count 32. It stores the full row. On the next cycle it gives a one-cycle `snoop_valid` pulse with that row on `snoop_data`.
- R8: A device-49 transfer that is a read, or that has a byte count other than 32, or that has a start register other than 2, changes no row and no index, and produces no snoop pulse.
- R9: When the index is at or above the RAM depth (64 rows by default), reads return all zeros and writes change no row. Auto-increment still applies.
- R10: The following transfers have no effect and produce no output: any other device ID, a byte count of 0, and a data range that runs past byte 31.
- R11: Device-48 transfers never raise `snoop_valid`, and writes never raise `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfr_valid | input | 1 | A transfer is presented this cycle |
| xfr_write | input | 1 | 1 = core stores into the block, 0 = core loads |
| xfr_dev | input | 8 | Device ID selecting plain or snoop access |
| xfr_reg | input | 5 | First core register number of the slice |
| xfr_len | input | 6 | Byte count of the transfer |
| xfr_wdata | input | 256 | Register slice image, byte k aligned to row byte k |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 256 | Row returned by a read |
| snoop_valid | output | 1 | One-cycle strobe for a snoop write |
| snoop_data | output | 256 | Full row stored by the snoop write |

## Verification
The bench fills every row through snoop writes with auto-increment on. It then pushes the index past the last row, so an implementation that used only the low address bits would alias to row 0 and hand back stale data instead of zeros. Several checks target the index logic. Reads at 510 and 511 catch a design that wraps to 0, because the read would return row 0. Repeated reads with auto-increment off catch an index that drifts. A control transfer with the wrong byte count catches a design that loads the index from it anyway. Partial writes at the first, a middle and the last register of the slice catch lane enables that are shifted or that spill into neighbouring bytes. Rejected snoop transfers and foreign device IDs would otherwise show up as an unexpected strobe, a changed row or a skipped row.

// File: rtl/wxr_pkg.sv
package wxr_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_CTRL,
    OP_WRITE,
    OP_READ,
    OP_SNOOP
  } op_e;
endpackage

// File: rtl/wxr_decode.sv
module wxr_decode
  import wxr_pkg::*;
#(
  parameter int ROW_BYTES  = 32,
  parameter int REG_BYTES  = 4,
  parameter int REG_NUM_W  = 5,
  parameter int LEN_W      = 6,
  parameter int DEV_W      = 8,
  parameter int DATA_BASE  = 2,
  parameter int CTRL_REG   = 10,
  parameter int CTRL_BYTES = 2,
  parameter logic [DEV_W-1:0] PLAIN_ID = 8'd48,
  parameter logic [DEV_W-1:0] SNOOP_ID = 8'd49
) (
  input  logic                 xfr_valid,
  input  logic                 xfr_write,
  input  logic [DEV_W-1:0]     xfr_dev,
  input  logic [REG_NUM_W-1:0] xfr_reg,
  input  logic [LEN_W-1:0]     xfr_len,
  output op_e                  op,
  output logic [ROW_BYTES-1:0] lane_en
);
  localparam int ROW_REGS = ROW_BYTES / REG_BYTES;

  int   rel;
  int   off_i;
  int   end_i;
  logic data_ok;
  logic snoop_ok;

  // slice geometry: which row bytes the register run covers
  always_comb begin
    rel      = int'(xfr_reg) - DATA_BASE;
    off_i    = rel * REG_BYTES;
    end_i    = off_i + int'(xfr_len);
    data_ok  = (rel >= 0) && (rel < ROW_REGS) && (xfr_len != '0) && (end_i <= ROW_BYTES);
    snoop_ok = (rel == 0) && (int'(xfr_len) == ROW_BYTES);
  end

  for (genvar b = 0; b < ROW_BYTES; b++) begin : g_lane
    assign lane_en[b] = (b >= off_i) && (b < end_i);
  end

  always_comb begin
    op = OP_NONE;
    if (xfr_valid) begin
      if (xfr_dev == PLAIN_ID) begin
        if (xfr_write && (int'(xfr_reg) == CTRL_REG)) begin
          if (int'(xfr_len) == CTRL_BYTES) op = OP_CTRL;
        end else if (data_ok) begin
          op = xfr_write ? OP_WRITE : OP_READ;
        end
      end else if ((xfr_dev == SNOOP_ID) && xfr_write && snoop_ok) begin
        op = OP_SNOOP;
      end
    end
  end
endmodule

// File: rtl/wxr_index.sv
module wxr_index
  import wxr_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  op_e              op,
  input  logic [IDX_W-1:0] ctrl_idx,
  input  logic             ctrl_aie,
  output logic [IDX_W-1:0] idx,
  output logic             aie
);
  localparam logic [IDX_W-1:0] IDX_LAST = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      aie <= 1'b0;
    end else begin
      unique case (op)
        OP_CTRL: begin
          idx <= ctrl_idx;
          aie <= ctrl_aie;
        end
        OP_WRITE, OP_READ, OP_SNOOP: begin
          // saturating step: no wrap back to row 0
          if (aie && (idx != IDX_LAST)) idx <= idx + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wxr_row_mem.sv
module wxr_row_mem #(
  parameter int DEPTH     = 64,
  parameter int ROW_BYTES = 32,
  parameter int IDX_W     = 9
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic                   re,
  input  logic [ROW_BYTES-1:0]   lane_en,
  input  logic [IDX_W-1:0]       idx,
  input  logic [ROW_BYTES*8-1:0] wdata,
  output logic                   rd_valid,
  output logic [ROW_BYTES*8-1:0] rd_data
);
  localparam int ROW_W  = ROW_BYTES * 8;
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ROW_W-1:0]  mem [DEPTH];
  logic [ROW_W-1:0]  rd_q;
  logic              oor_q;
  logic              in_range;
  logic [ADDR_W-1:0] addr;

  assign in_range = int'(idx) < DEPTH;
  assign addr     = idx[ADDR_W-1:0];

  // byte-enable write port, kept in one process for block-RAM inference
  always_ff @(posedge clk) begin
    if (we && in_range) begin
      for (int b = 0; b < ROW_BYTES; b++) begin
        if (lane_en[b]) mem[addr][b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (re) rd_q <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      oor_q    <= 1'b0;
    end else begin
      rd_valid <= re;
      if (re) oor_q <= !in_range;
    end
  end

  assign rd_data = oor_q ? '0 : rd_q;
endmodule

// File: rtl/wide_xfer_ram.sv
module wide_xfer_ram
  import wxr_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int ROW_BYTES = 32,
  parameter int REG_BYTES = 4,
  parameter int IDX_W     = 9,
  parameter int AIE_BIT   = 15,
  parameter int REG_NUM_W = 5,
  parameter int LEN_W     = 6,
  parameter int DEV_W     = 8,
  parameter int DATA_BASE = 2,
  parameter int CTRL_REG  = 10,
  parameter logic [DEV_W-1:0] PLAIN_ID = 8'd48,
  parameter logic [DEV_W-1:0] SNOOP_ID = 8'd49
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   xfr_valid,
  input  logic                   xfr_write,
  input  logic [DEV_W-1:0]       xfr_dev,
  input  logic [REG_NUM_W-1:0]   xfr_reg,
  input  logic [LEN_W-1:0]       xfr_len,
  input  logic [ROW_BYTES*8-1:0] xfr_wdata,
  output logic                   rd_valid,
  output logic [ROW_BYTES*8-1:0] rd_data,
  output logic                   snoop_valid,
  output logic [ROW_BYTES*8-1:0] snoop_data
);
  op_e                  op;
  logic [ROW_BYTES-1:0] lane_en;
  logic [IDX_W-1:0]     idx_q;
  logic                 aie_q;
  logic                 mem_we;
  logic                 mem_re;

  wxr_decode #(
    .ROW_BYTES(ROW_BYTES), .REG_BYTES(REG_BYTES), .REG_NUM_W(REG_NUM_W),
    .LEN_W(LEN_W), .DEV_W(DEV_W), .DATA_BASE(DATA_BASE), .CTRL_REG(CTRL_REG),
    .CTRL_BYTES(2), .PLAIN_ID(PLAIN_ID), .SNOOP_ID(SNOOP_ID)
  ) u_decode (
    .xfr_valid(xfr_valid), .xfr_write(xfr_write), .xfr_dev(xfr_dev),
    .xfr_reg(xfr_reg), .xfr_len(xfr_len), .op(op), .lane_en(lane_en)
  );

  wxr_index #(.IDX_W(IDX_W)) u_index (
    .clk(clk), .rst(rst), .op(op),
    .ctrl_idx(xfr_wdata[IDX_W-1:0]), .ctrl_aie(xfr_wdata[AIE_BIT]),
    .idx(idx_q), .aie(aie_q)
  );

  assign mem_we = !rst && ((op == OP_WRITE) || (op == OP_SNOOP));
  assign mem_re = !rst && (op == OP_READ);

  wxr_row_mem #(.DEPTH(DEPTH), .ROW_BYTES(ROW_BYTES), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .rst(rst), .we(mem_we), .re(mem_re), .lane_en(lane_en),
    .idx(idx_q), .wdata(xfr_wdata), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // snoop side channel: registered strobe plus the stored row
  always_ff @(posedge clk) begin
    if (rst) begin
      snoop_valid <= 1'b0;
    end else begin
      snoop_valid <= (op == OP_SNOOP);
    end
  end

  always_ff @(posedge clk) begin
    if (op == OP_SNOOP) snoop_data <= xfr_wdata;
  end
endmodule

// File: rtl/wxr_checker.sv
module wxr_checker #(
  parameter int DEPTH     = 64,
  parameter int ROW_BYTES = 32,
  parameter int IDX_W     = 9,
  parameter int REG_NUM_W = 5,
  parameter int LEN_W     = 6,
  parameter int DEV_W     = 8,
  parameter int DATA_BASE = 2,
  parameter int CTRL_REG  = 10,
  parameter logic [DEV_W-1:0] PLAIN_ID = 8'd48,
  parameter logic [DEV_W-1:0] SNOOP_ID = 8'd49
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   xfr_valid,
  input logic                   xfr_write,
  input logic [DEV_W-1:0]       xfr_dev,
  input logic [REG_NUM_W-1:0]   xfr_reg,
  input logic [LEN_W-1:0]       xfr_len,
  input logic [ROW_BYTES*8-1:0] xfr_wdata,
  input logic                   rd_valid,
  input logic [ROW_BYTES*8-1:0] rd_data,
  input logic                   snoop_valid,
  input logic [ROW_BYTES*8-1:0] snoop_data,
  input logic [IDX_W-1:0]       idx
);
  localparam logic [LEN_W-1:0]     FULL_LEN = LEN_W'(ROW_BYTES);
  localparam logic [REG_NUM_W-1:0] BASE_REG = REG_NUM_W'(DATA_BASE);
  localparam logic [REG_NUM_W-1:0] CTL_REG  = REG_NUM_W'(CTRL_REG);
  localparam logic [IDX_W-1:0]     IDX_LAST = '1;

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (xfr_valid && !xfr_write && xfr_dev == PLAIN_ID && xfr_reg == BASE_REG && xfr_len == FULL_LEN)
    |=> rd_valid); // R3

  AST_RD_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(xfr_valid && !xfr_write && xfr_dev == PLAIN_ID)); // R3

  AST_SNOOP_FULL_ONLY: assert property (@(posedge clk) disable iff (rst)
    snoop_valid |-> $past(xfr_valid && xfr_write && xfr_dev == SNOOP_ID &&
                          xfr_len == FULL_LEN && xfr_reg == BASE_REG)); // R8

  AST_SNOOP_ECHO: assert property (@(posedge clk) disable iff (rst)
    snoop_valid |-> (snoop_data == $past(xfr_wdata))); // R7

  AST_IDX_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (idx == IDX_LAST && !(xfr_valid && xfr_write && xfr_dev == PLAIN_ID && xfr_reg == CTL_REG))
    |=> (idx == IDX_LAST)); // R6

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (xfr_valid && !xfr_write && xfr_dev == PLAIN_ID && int'(idx) >= DEPTH)
    |=> (!rd_valid || rd_data == '0)); // R9

  AST_FOREIGN_DEV_QUIET: assert property (@(posedge clk) disable iff (rst)
    (xfr_valid && xfr_dev != PLAIN_ID && xfr_dev != SNOOP_ID)
    |=> (!rd_valid && !snoop_valid)); // R10

  AST_PLAIN_NO_SNOOP: assert property (@(posedge clk) disable iff (rst)
    (xfr_valid && xfr_dev == PLAIN_ID) |=> !snoop_valid); // R11

  AST_WRITE_NO_RD: assert property (@(posedge clk) disable iff (rst)
    (xfr_valid && xfr_write) |=> !rd_valid); // R11
endmodule

bind wide_xfer_ram wxr_checker #(
  .DEPTH(DEPTH), .ROW_BYTES(ROW_BYTES), .IDX_W(IDX_W), .REG_NUM_W(REG_NUM_W),
  .LEN_W(LEN_W), .DEV_W(DEV_W), .DATA_BASE(DATA_BASE), .CTRL_REG(CTRL_REG),
  .PLAIN_ID(PLAIN_ID), .SNOOP_ID(SNOOP_ID)
) chk_i (
  .clk(clk), .rst(rst), .xfr_valid(xfr_valid), .xfr_write(xfr_write),
  .xfr_dev(xfr_dev), .xfr_reg(xfr_reg), .xfr_len(xfr_len), .xfr_wdata(xfr_wdata),
  .rd_valid(rd_valid), .rd_data(rd_data), .snoop_valid(snoop_valid),
  .snoop_data(snoop_data), .idx(idx_q)
);

// File: tb/wide_xfer_ram_tb_top.sv
`timescale 1ns/1ps
module wide_xfer_ram_tb_top;
  localparam int DEPTH = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         xfr_valid = 1'b0;
  logic         xfr_write = 1'b0;
  logic [7:0]   xfr_dev = '0;
  logic [4:0]   xfr_reg = '0;
  logic [5:0]   xfr_len = '0;
  logic [255:0] xfr_wdata = '0;
  logic         rd_valid;
  logic [255:0] rd_data;
  logic         snoop_valid;
  logic [255:0] snoop_data;

  always #4 clk = ~clk;

  wide_xfer_ram dut_i (
    .clk(clk), .rst(rst), .xfr_valid(xfr_valid), .xfr_write(xfr_write),
    .xfr_dev(xfr_dev), .xfr_reg(xfr_reg), .xfr_len(xfr_len), .xfr_wdata(xfr_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .snoop_valid(snoop_valid),
    .snoop_data(snoop_data)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur_tag = "R1";

  // behavioural reference state
  logic [7:0]   m_mem [DEPTH][32];
  int           m_idx = 0;
  bit           m_aie = 0;
  bit           e_rv  = 0;
  bit           e_sv  = 0;
  logic [255:0] e_rd  = '0;
  logic [255:0] e_sd  = '0;
  string        e_tag = "R1";

  function automatic logic [255:0] row_vec(int r);
    logic [255:0] v;
    for (int b = 0; b < 32; b++) v[b*8 +: 8] = m_mem[r][b];
    return v;
  endfunction

  function automatic logic [255:0] pat(int seed);
    logic [255:0] v;
    for (int b = 0; b < 32; b++) v[b*8 +: 8] = 8'((seed * 7 + b * 13 + 1) & 255);
    return v;
  endfunction

  task automatic step_idx();
    if (m_aie && m_idx < 511) m_idx++;
  endtask

  always @(posedge clk) begin
    e_rv  = 0;
    e_sv  = 0;
    e_tag = cur_tag;
    if (rst) begin
      m_idx = 0;
      m_aie = 0;
    end else if (xfr_valid) begin
      int rel, off, lim;
      rel = int'(xfr_reg) - 2;
      off = rel * 4;
      lim = off + int'(xfr_len);
      if (xfr_dev == 8'd48) begin
        if (xfr_write && xfr_reg == 5'd10) begin
          if (xfr_len == 6'd2) begin
            m_idx = int'(xfr_wdata[8:0]);
            m_aie = xfr_wdata[15];
          end
        end else if (rel >= 0 && rel < 8 && xfr_len != 0 && lim <= 32) begin
          if (xfr_write) begin
            if (m_idx < DEPTH)
              for (int b = off; b < lim; b++) m_mem[m_idx][b] = xfr_wdata[b*8 +: 8];
          end else begin
            e_rv = 1;
            e_rd = (m_idx < DEPTH) ? row_vec(m_idx) : '0;
          end
          step_idx();
        end
      end else if (xfr_dev == 8'd49 && xfr_write && rel == 0 && xfr_len == 6'd32) begin
        if (m_idx < DEPTH)
          for (int b = 0; b < 32; b++) m_mem[m_idx][b] = xfr_wdata[b*8 +: 8];
        e_sv = 1;
        e_sd = xfr_wdata;
        step_idx();
      end
    end
  end

  task automatic check(bit ok, string what, logic [255:0] act, logic [255:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", e_tag, what, act, exp);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check(rd_valid === e_rv, "rd_valid", 256'(rd_valid), 256'(e_rv));
      check(snoop_valid === e_sv, "snoop_valid", 256'(snoop_valid), 256'(e_sv));
      if (e_rv) check(rd_data === e_rd, "rd_data", rd_data, e_rd);
      if (e_sv) check(snoop_data === e_sd, "snoop_data", snoop_data, e_sd);
    end
  end

  task automatic xfr(string tag, bit wr, logic [7:0] dev, logic [4:0] rg,
                     logic [5:0] len, logic [255:0] d);
    @(negedge clk);
    cur_tag   = tag;
    xfr_valid = 1'b1;
    xfr_write = wr;
    xfr_dev   = dev;
    xfr_reg   = rg;
    xfr_len   = len;
    xfr_wdata = d;
    @(negedge clk);
    xfr_valid = 1'b0;
  endtask

  task automatic ctrl(string tag, int idx, bit aie);
    logic [255:0] d;
    d = '0;
    d[8:0] = 9'(idx);
    d[15]  = aie;
    d[12]  = 1'b1; // stray bit in the unused field
    xfr(tag, 1, 8'd48, 5'd10, 6'd2, d);
  endtask

  task automatic rd(string tag);
    xfr(tag, 0, 8'd48, 5'd2, 6'd32, '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    cur_tag = "R1";
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    // R7/R5: fill every row through snoop writes with auto-increment on
    ctrl("R4", 0, 1);
    for (int r = 0; r < DEPTH; r++) xfr("R7", 1, 8'd49, 5'd2, 6'd32, pat(r));
    // R9: index now beyond depth
    rd("R9");
    xfr("R9", 1, 8'd48, 5'd2, 6'd32, pat(99));
    ctrl("R9", 0, 0);
    rd("R9");
    ctrl("R9", 63, 0);
    rd("R9");
    // R5: auto-increment off keeps the index
    ctrl("R5", 5, 0);
    rd("R5");
    rd("R5");
    // R2: partial writes at first, middle and last register
    xfr("R2", 1, 8'd48, 5'd3, 6'd5, pat(200));
    xfr("R2", 1, 8'd48, 5'd9, 6'd4, pat(201));
    xfr("R2", 1, 8'd48, 5'd2, 6'd1, pat(202));
    rd("R2");
    // R4: wrong-size control transfers ignored
    xfr("R4", 1, 8'd48, 5'd10, 6'd4, 256'h7);
    xfr("R4", 1, 8'd48, 5'd10, 6'd1, 256'h8);
    rd("R4");
    // R5: stepping regardless of size
    ctrl("R5", 10, 1);
    xfr("R5", 0, 8'd48, 5'd4, 6'd1, '0);
    rd("R5");
    xfr("R5", 1, 8'd48, 5'd2, 6'd3, pat(210));
    rd("R5");
    ctrl("R5", 12, 0);
    rd("R5");
    // R8: rejected snoop transfers
    ctrl("R8", 20, 1);
    xfr("R8", 1, 8'd49, 5'd2, 6'd16, pat(220));
    xfr("R8", 1, 8'd49, 5'd3, 6'd28, pat(221));
    xfr("R8", 0, 8'd49, 5'd2, 6'd32, '0);
    rd("R8");
    // R10: foreign IDs, zero length, overflowing slice
    ctrl("R10", 21, 1);
    xfr("R10", 1, 8'd7, 5'd2, 6'd32, pat(230));
    xfr("R10", 0, 8'd30, 5'd2, 6'd32, '0);
    xfr("R10", 1, 8'd48, 5'd2, 6'd0, pat(231));
    xfr("R10", 1, 8'd48, 5'd9, 6'd8, pat(232));
    xfr("R10", 0, 8'd48, 5'd1, 6'd4, '0);
    rd("R10");
    // R11: plain write next to a snoop write
    xfr("R11", 1, 8'd48, 5'd2, 6'd32, pat(240));
    xfr("R11", 1, 8'd49, 5'd2, 6'd32, pat(241));
    ctrl("R11", 22, 0);
    rd("R11");
    // R6: saturation at the top of the index range
    ctrl("R6", 510, 1);
    rd("R6");
    rd("R6");
    rd("R6");
    rd("R6");
    // R1: reset returns index to 0 with auto-increment off
    do_reset();
    rd("R1");
    rd("R1");
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule